// File: doc/BRIEF.md
# Variable-Length Instruction Address Generator

This block sits behind an instruction fetch buffer in a processor front end that runs a base-displacement instruction set with variable-length instructions. For each instruction it is handed, it works out the format and the length in bytes from the leading opcode bits alone, forms the memory operand addresses the format calls for, and computes where the next sequential instruction starts. Register reads are supplied alongside the instruction as a flattened vector holding the low address bits of all sixteen general registers.

Instructions enter on a valid/ready stream and leave on another, one register stage later. An instruction is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output holds nothing or the output is being consumed in the same cycle, so a stalled consumer stops the producer at once without loss. While `out_valid` is high and `out_ready` is low, every output stays unchanged.

The instruction buffer is left-justified: byte 0 (the first opcode byte) occupies bits 47:40, byte 1 bits 39:32, and so on down to byte 5 at bits 7:0. Bytes beyond the decoded length are ignored.

Top module: `iag_top`

## Requirements
- R1: Length comes from opcode bits 7:6 (buffer bits 47:46): 00 gives 2 bytes, 01 and 10 give 4 bytes, 11 gives 6 bytes; `out_ilen` carries that byte count and `out_next` equals the instruction address plus that count, modulo 2^24.
- R2: Format code on `out_fmt`: 0 register-register for opcode bits 7:6 = 00; 1 register-indexed for 01; 3 storage (two-byte opcode) for 10 when opcode bits 7:4 = 1011; 2 storage-immediate for any other 10 opcode; 4 storage-to-storage for 11. `out_nea` is 0 for format 0, 2 for format 4 and 1 otherwise.
- R3: Register-indexed: index number in bits 35:32, base in bits 31:28, displacement in bits 27:16; `out_ea1` = base value + index value + displacement, modulo 2^24.
- R4: Storage-immediate and storage formats: base in bits 31:28, displacement in bits 27:16, `out_ea1` = base value + displacement; for storage-immediate, `out_imm` carries bits 39:32.
- R5: Storage-to-storage: `out_fld_len` carries bits 39:32; `out_ea1` uses base bits 31:28 and displacement bits 27:16; `out_ea2` uses base bits 15:12 and displacement bits 11:0.
- R6: A base or index number of 0 adds zero, whatever value register 0 holds; displacements are unsigned 12-bit.
- R7: Outputs a format does not produce are zero: `out_ea1` for format 0, `out_ea2` and `out_fld_len` except in format 4, `out_imm` except in format 2 (so the second opcode byte of the storage format never appears there).
- R8: An instruction accepted on an edge appears with `out_valid` high right after that edge; `in_ready` is low only while `out_valid` is high and `out_ready` low; a stalled result holds all outputs steady.
- R9: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take an instruction |
| in_ibuf | input | 48 | Left-justified instruction bytes |
| in_pc | input | 24 | Address of the instruction |
| in_gpr | input | 384 | Register k value at bits 24k+23:24k |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_fmt | output | 3 | Format code |
| out_ilen | output | 3 | Length in bytes |
| out_nea | output | 2 | Number of operand addresses |
| out_ea1 | output | 24 | First operand address |
| out_ea2 | output | 24 | Second operand address |
| out_imm | output | 8 | Immediate byte |
| out_fld_len | output | 8 | Storage-to-storage length field |
| out_next | output | 24 | Next sequential instruction address |

## Verification
The hardest case to reach from the ports is a second instruction waiting at the input while the first is stalled, followed by the cycle where the stall lifts and the two swap in a single edge. The bench holds `out_ready` low across an accepted instruction, presents a different one for several cycles while checking the first stays frozen and `in_ready` stays low, then raises `out_ready` and checks that the second instruction's addresses arrive on the very next edge. Address wrap is reached by loading a register with a value near 2^24 and by placing an instruction at the top of the address space.

// File: rtl/iag_pkg.sv
package iag_pkg;

  typedef enum logic [2:0] {
    FMT_RR = 3'd0,
    FMT_RX = 3'd1,
    FMT_SI = 3'd2,
    FMT_S  = 3'd3,
    FMT_SS = 3'd4
  } fmt_e;

  localparam logic [3:0] STORAGE_OP_NIBBLE = 4'b1011;

  typedef struct packed {
    fmt_e       fmt;
    logic [2:0] ilen;
    logic [1:0] nea;
  } dec_t;

endpackage

// File: rtl/iag_decode.sv
module iag_decode
  import iag_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  output dec_t            dec
);

  logic [1:0] len_code;
  logic [3:0] hi_nib;

  assign len_code = opcode[OP_W-1 -: 2];
  assign hi_nib   = opcode[OP_W-1 -: 4];

  always_comb begin
    dec = '0;
    unique case (len_code)
      2'b00: begin
        dec.fmt  = FMT_RR;
        dec.ilen = 3'd2;
        dec.nea  = 2'd0;
      end
      2'b01: begin
        dec.fmt  = FMT_RX;
        dec.ilen = 3'd4;
        dec.nea  = 2'd1;
      end
      2'b10: begin
        dec.fmt  = (hi_nib == STORAGE_OP_NIBBLE) ? FMT_S : FMT_SI;
        dec.ilen = 3'd4;
        dec.nea  = 2'd1;
      end
      default: begin
        dec.fmt  = FMT_SS;
        dec.ilen = 3'd6;
        dec.nea  = 2'd2;
      end
    endcase
  end

endmodule

// File: rtl/iag_agen.sv
module iag_agen #(
  parameter int NREG   = 16,
  parameter int ADDR_W = 24,
  parameter int DISP_W = 12,
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic [NREG*ADDR_W-1:0] gpr,
  input  logic                   en,
  input  logic                   index_en,
  input  logic [RIDX_W-1:0]      base_sel,
  input  logic [RIDX_W-1:0]      index_sel,
  input  logic [DISP_W-1:0]      disp,
  output logic [ADDR_W-1:0]      ea
);

  logic [ADDR_W-1:0] base_v;
  logic [ADDR_W-1:0] index_v;

  always_comb begin
    base_v  = '0;
    index_v = '0;
    for (int k = 1; k < NREG; k++) begin
      if (base_sel == RIDX_W'(k))
        base_v = gpr[k*ADDR_W +: ADDR_W];
      if (index_en && index_sel == RIDX_W'(k))
        index_v = gpr[k*ADDR_W +: ADDR_W];
    end
  end

  assign ea = en ? (base_v + index_v + ADDR_W'(disp)) : '0;

endmodule

// File: rtl/iag_outreg.sv
module iag_outreg #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid)
        out_pay <= in_pay;
    end
  end

endmodule

// File: rtl/iag_top.sv
module iag_top
  import iag_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int ADDR_W = 24,
  parameter int DISP_W = 12,
  parameter int BYTE_W = 8,
  parameter int MAX_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [MAX_BYTES*BYTE_W-1:0] in_ibuf,
  input  logic [ADDR_W-1:0]       in_pc,
  input  logic [NREG*ADDR_W-1:0]  in_gpr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [2:0]              out_fmt,
  output logic [2:0]              out_ilen,
  output logic [1:0]              out_nea,
  output logic [ADDR_W-1:0]       out_ea1,
  output logic [ADDR_W-1:0]       out_ea2,
  output logic [BYTE_W-1:0]       out_imm,
  output logic [BYTE_W-1:0]       out_fld_len,
  output logic [ADDR_W-1:0]       out_next
);

  localparam int IBUF_W = MAX_BYTES * BYTE_W;
  localparam int RIDX_W = $clog2(NREG);
  localparam int NLANE  = 2;
  // byte boundaries of the left-justified buffer
  localparam int OP_HI  = IBUF_W - 1;
  localparam int B1_HI  = IBUF_W - BYTE_W - 1;
  localparam int B2_HI  = IBUF_W - 2*BYTE_W - 1;
  localparam int B4_HI  = IBUF_W - 4*BYTE_W - 1;
  localparam int PAY_W  = 3 + 3 + 2 + 3*ADDR_W + 2*BYTE_W;

  dec_t dec;

  iag_decode #(.OP_W(BYTE_W)) u_dec (
    .opcode (in_ibuf[OP_HI -: BYTE_W]),
    .dec    (dec)
  );

  logic [NLANE-1:0]             lane_en;
  logic [NLANE-1:0]             lane_idx_en;
  logic [NLANE-1:0][RIDX_W-1:0] lane_base;
  logic [NLANE-1:0][RIDX_W-1:0] lane_index;
  logic [NLANE-1:0][DISP_W-1:0] lane_disp;
  logic [NLANE-1:0][ADDR_W-1:0] lane_ea;

  // lane 0: first storage operand, lane 1: second (storage-to-storage)
  assign lane_en[0]     = (dec.fmt != FMT_RR);
  assign lane_idx_en[0] = (dec.fmt == FMT_RX);
  assign lane_index[0]  = in_ibuf[B1_HI - RIDX_W -: RIDX_W];
  assign lane_base[0]   = in_ibuf[B2_HI -: RIDX_W];
  assign lane_disp[0]   = in_ibuf[B2_HI - RIDX_W -: DISP_W];

  assign lane_en[1]     = (dec.fmt == FMT_SS);
  assign lane_idx_en[1] = 1'b0;
  assign lane_index[1]  = '0;
  assign lane_base[1]   = in_ibuf[B4_HI -: RIDX_W];
  assign lane_disp[1]   = in_ibuf[B4_HI - RIDX_W -: DISP_W];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    iag_agen #(
      .NREG   (NREG),
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W),
      .RIDX_W (RIDX_W)
    ) u_agen (
      .gpr       (in_gpr),
      .en        (lane_en[g]),
      .index_en  (lane_idx_en[g]),
      .base_sel  (lane_base[g]),
      .index_sel (lane_index[g]),
      .disp      (lane_disp[g]),
      .ea        (lane_ea[g])
    );
  end

  logic [BYTE_W-1:0] byte1;
  logic [BYTE_W-1:0] imm_d;
  logic [BYTE_W-1:0] fld_d;
  logic [ADDR_W-1:0] next_d;

  assign byte1  = in_ibuf[B1_HI -: BYTE_W];
  assign imm_d  = (dec.fmt == FMT_SI) ? byte1 : '0;
  assign fld_d  = (dec.fmt == FMT_SS) ? byte1 : '0;
  assign next_d = in_pc + ADDR_W'(dec.ilen);

  logic [PAY_W-1:0] pay_d;
  logic [PAY_W-1:0] pay_q;

  assign pay_d = {dec.fmt, dec.ilen, dec.nea, lane_ea[0], lane_ea[1],
                  imm_d, fld_d, next_d};

  iag_outreg #(.PAY_W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pay    (pay_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pay   (pay_q)
  );

  assign {out_fmt, out_ilen, out_nea, out_ea1, out_ea2,
          out_imm, out_fld_len, out_next} = pay_q;

endmodule

// File: rtl/iag_chk.sv
module iag_chk #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2:0]        out_fmt,
  input logic [2:0]        out_ilen,
  input logic [1:0]        out_nea,
  input logic [ADDR_W-1:0] out_ea1,
  input logic [ADDR_W-1:0] out_ea2,
  input logic [BYTE_W-1:0] out_imm,
  input logic [BYTE_W-1:0] out_fld_len,
  input logic [ADDR_W-1:0] out_next
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ea1) && $stable(out_ea2)
      && $stable(out_fmt) && $stable(out_next) && $stable(out_imm));

  // R8
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R1
  len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_fmt == 3'd0) ? (out_ilen == 3'd2) :
                   (out_fmt == 3'd4) ? (out_ilen == 3'd6) : (out_ilen == 3'd4)));

  // R2
  nea_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_fmt == 3'd0) ? (out_nea == 2'd0) :
                   (out_fmt == 3'd4) ? (out_nea == 2'd2) : (out_nea == 2'd1)));

  // R7
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt != 3'd4 |-> out_ea2 == '0 && out_fld_len == '0);

  // R7
  imm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt != 3'd2 |-> out_imm == '0);

endmodule

bind iag_top iag_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_fmt     (out_fmt),
  .out_ilen    (out_ilen),
  .out_nea     (out_nea),
  .out_ea1     (out_ea1),
  .out_ea2     (out_ea2),
  .out_imm     (out_imm),
  .out_fld_len (out_fld_len),
  .out_next    (out_next)
);

// File: tb/test_iag_top.sv
module test_iag_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [47:0]  in_ibuf = '0;
  logic [23:0]  in_pc = '0;
  logic [383:0] in_gpr;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [2:0]   out_fmt;
  logic [2:0]   out_ilen;
  logic [1:0]   out_nea;
  logic [23:0]  out_ea1;
  logic [23:0]  out_ea2;
  logic [7:0]   out_imm;
  logic [7:0]   out_fld_len;
  logic [23:0]  out_next;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iag_top i_iag_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ibuf(in_ibuf), .in_pc(in_pc), .in_gpr(in_gpr),
    .out_valid(out_valid), .out_ready(out_ready), .out_fmt(out_fmt),
    .out_ilen(out_ilen), .out_nea(out_nea), .out_ea1(out_ea1),
    .out_ea2(out_ea2), .out_imm(out_imm), .out_fld_len(out_fld_len),
    .out_next(out_next)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] ib, input logic [23:0] pc);
    @(negedge clk);
    in_ibuf  = ib;
    in_pc    = pc;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [2:0] fmt, input logic [2:0] ilen,
                            input logic [1:0] nea, input logic [23:0] ea1, input logic [23:0] ea2,
                            input logic [7:0] imm, input logic [7:0] fl, input logic [23:0] nxt);
    chk(32'(out_valid), 1, {tag, " valid"});
    chk(32'(out_fmt), 32'(fmt), {tag, " fmt"});
    chk(32'(out_ilen), 32'(ilen), {tag, " ilen"});
    chk(32'(out_nea), 32'(nea), {tag, " nea"});
    chk(32'(out_ea1), 32'(ea1), {tag, " ea1"});
    chk(32'(out_ea2), 32'(ea2), {tag, " ea2"});
    chk(32'(out_imm), 32'(imm), {tag, " imm"});
    chk(32'(out_fld_len), 32'(fl), {tag, " fld_len"});
    chk(32'(out_next), 32'(nxt), {tag, " next"});
  endtask

  // R9
  task automatic t_reset();
    chk(32'(out_valid), 0, "R9 reset out_valid");
    chk(32'(in_ready), 1, "R9 reset in_ready");
  endtask

  // R1 R2 R7: register-register, byte 1 must not leak to imm
  task automatic t_rr();
    send(48'h1A35_0000_0000, 24'h001000);
    expect_out("R1 R2 R7 rr", 3'd0, 3'd2, 2'd0, 24'h0, 24'h0, 8'h0, 8'h0, 24'h001002);
  endtask

  // R3: base 3 + index 2 + 0x123
  task automatic t_rx();
    send(48'h5812_3123_0000, 24'h002000);
    expect_out("R3 rx", 3'd1, 3'd4, 2'd1, 24'h050628, 24'h0, 8'h0, 8'h0, 24'h002004);
  endtask

  // R6: base and index number 0 add zero although register 0 is nonzero
  task automatic t_rx_zero();
    send(48'h5810_0FFF_0000, 24'h000100);
    expect_out("R6 rx zero", 3'd1, 3'd4, 2'd1, 24'h000FFF, 24'h0, 8'h0, 8'h0, 24'h000104);
  endtask

  // R3 R1: address sum and next address wrap modulo 2^24
  task automatic t_wrap();
    send(48'h581E_E201_0000, 24'hFFFFFE);
    expect_out("R3 R1 wrap", 3'd1, 3'd4, 2'd1, 24'h000001, 24'h0, 8'h0, 8'h0, 24'h000002);
  endtask

  // R4: storage-immediate
  task automatic t_si();
    send(48'h925C_2010_0000, 24'h003000);
    expect_out("R4 si", 3'd2, 3'd4, 2'd1, 24'h020212, 24'h0, 8'h5C, 8'h0, 24'h003004);
  endtask

  // R2 R4 R7: storage format, second opcode byte not on imm
  task automatic t_s();
    send(48'hB218_10FF_0000, 24'h003100);
    expect_out("R2 R4 R7 s", 3'd3, 3'd4, 2'd1, 24'h010200, 24'h0, 8'h0, 8'h0, 24'h003104);
  endtask

  // R5: storage-to-storage
  task automatic t_ss();
    send(48'hD207_3004_FABC, 24'h004000);
    expect_out("R5 ss", 3'd4, 3'd6, 2'd2, 24'h030307, 24'h0F19CB, 8'h0, 8'h07, 24'h004006);
  endtask

  // R5 R6: both bases zero
  task automatic t_ss_zero();
    send(48'hD2FF_0100_0001, 24'h004100);
    expect_out("R5 R6 ss zero", 3'd4, 3'd6, 2'd2, 24'h000100, 24'h000001, 8'h0, 8'hFF, 24'h004106);
  endtask

  // R8: stall, held input, release with same-edge swap
  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    in_ibuf   = 48'h925C_2010_0000;
    in_pc     = 24'h005000;
    in_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(32'(out_valid), 1, "R8 stall valid");
    chk(32'(in_ready), 0, "R8 stall in_ready low");
    in_ibuf = 48'h5812_3123_0000;
    in_pc   = 24'h006000;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(32'(out_ea1), 32'h020212, "R8 stall ea1 held");
      chk(32'(out_next), 32'h005004, "R8 stall next held");
      chk(32'(in_ready), 0, "R8 stall ready held");
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(32'(out_valid), 1, "R8 swap valid");
    chk(32'(out_ea1), 32'h050628, "R8 swap ea1");
    chk(32'(out_next), 32'h006004, "R8 swap next");
    @(posedge clk);
    @(negedge clk);
    chk(32'(out_valid), 0, "R8 drain valid");
    chk(32'(in_ready), 1, "R8 drain ready");
  endtask

  initial begin
    for (int k = 0; k < 16; k++)
      in_gpr[k*24 +: 24] = 24'(k * 24'h010101);
    in_gpr[0*24 +: 24]  = 24'h777777;
    in_gpr[14*24 +: 24] = 24'hFFFF00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_rr();
    t_rx();
    t_rx_zero();
    t_wrap();
    t_si();
    t_s();
    t_ss();
    t_ss_zero();
    t_stall();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule